// File: doc/BRIEF.md
# Binary XNOR-Popcount Convolution Core

This core computes one output channel of a binarized convolution or dense layer. Each beat brings an activation word and a weight word of `NI` bits, where each bit stands for +1 (bit 1) or -1 (bit 0). The product of two such values is their XNOR, so a dot product reduces to counting agreeing bit positions. The batch-normalisation step that follows a layer is folded into a per-filter signed threshold. The core therefore emits a single binarized bit per dot product and needs no multiplier and no normalisation arithmetic.

Before a dot product, the filter's threshold and its length in words are loaded. On the first beat, the accumulator is preset to the total bit count minus the threshold. Each beat then subtracts twice the number of disagreeing positions. The result bit is the inverted sign of the final sum. Several consecutive results can be merged by a 2x2 max pool, which for binary values is an OR. The pooled bit leaves the core when the dot product that closes the pooling window ends.

Top module: `bnn_xnor_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` and `out_bit` are 0.
- R2: For a beat, the signed contribution is (agreeing positions) minus (disagreeing positions), where a position agrees when the activation and weight bits are equal. Within a dot product the internal running sum never increases from one beat to the next.
- R3: A cycle with `cfg_load` high latches `cfg_tau` (16-bit two's complement) and `cfg_words` (word count) for the dot products that begin on later cycles. The accumulator is preset to `cfg_words*NI - cfg_tau` on the beat flagged `in_first`.
- R4: A finished dot product with signed sum S yields bit 1 when S >= tau and bit 0 when S < tau (1 encodes positive, 0 negative). This includes S equal to tau exactly.
- R5: The accumulator is at least 20 bits wide. The extreme cases (all 64 words agreeing with tau = -32768, and all disagreeing with tau = 32767) produce the correct bits without wrap-around.
- R6: The emitted bit is the OR of the result bits of all dot products since the previous emission. The pooling register is cleared when a bit is emitted.
- R7: When every dot product is closed with `pool_last` = 1 (pool size 1), each result bit is emitted on its own.
- R8: `out_valid` is a one-cycle pulse, high exactly in the cycle after a beat with `in_valid`, `in_last` and `pool_last` all high, and low in every other cycle. `out_bit` holds its value between pulses.
- R9: Cycles with `in_valid` low are ignored: their data and flags change neither the sum nor the pooling state.
- R10: A dot product of one word (`in_first` and `in_last` on the same beat) is computed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Latch threshold and word count |
| cfg_tau | input | 16 | Signed per-filter threshold |
| cfg_words | input | $clog2(MAX_WORDS+1) | Words per dot product |
| in_valid | input | 1 | Beat carries data |
| in_first | input | 1 | First beat of a dot product |
| in_last | input | 1 | Last beat of a dot product |
| pool_last | input | 1 | With `in_last`: this result closes the pooling window |
| act_word | input | NI | Binary activations |
| wgt_word | input | NI | Binary weights |
| out_valid | output | 1 | Pooled bit valid pulse |
| out_bit | output | 1 | Pooled binarized activation |

## Verification
On every cycle, the assertions check the timing of the output pulse relative to a closing beat, the clearing of the pooling register on emission, the non-increasing running sum within a dot product, and the freezing of all state during idle cycles. The numeric correctness of each bit cannot be checked by a property alone. The bench scenarios show it: the exact tie S = tau, the extreme thresholds, single-word products, OR pooling over windows of mixed bits, and threshold reloads between filters. Each scenario is compared against an integer ±1 dot-product model.

// File: rtl/bnn_core_pkg.sv
package bnn_core_pkg;
    localparam int TAU_W = 16;

    typedef struct packed {
        logic held;
        logic obit;
        logic ovalid;
    } pool_state_t;
endpackage

// File: rtl/bnn_mismatch_count.sv
module bnn_mismatch_count #(
    parameter int NI    = 64,
    parameter int MIS_W = $clog2(NI + 1)
) (
    input  logic [NI-1:0]    act,
    input  logic [NI-1:0]    wgt,
    output logic [MIS_W-1:0] count
);
    localparam int LANE  = 8;
    localparam int LANES = NI / LANE;

    logic [NI-1:0] diff;
    logic [3:0]    lane_cnt [LANES];

    assign diff = act ^ wgt;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            lane_cnt[g] = '0;
            for (int b = 0; b < LANE; b++) begin
                lane_cnt[g] = lane_cnt[g] + 4'(diff[g*LANE + b]);
            end
        end
    end

    always_comb begin
        count = '0;
        for (int l = 0; l < LANES; l++) begin
            count = count + MIS_W'(lane_cnt[l]);
        end
    end
endmodule

// File: rtl/bnn_thresh_acc.sv
module bnn_thresh_acc
    import bnn_core_pkg::*;
#(
    parameter int NI        = 64,
    parameter int ACC_W     = 20,
    parameter int CNT_W     = 7,
    parameter int MIS_W     = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic signed [TAU_W-1:0] cfg_tau,
    input  logic [CNT_W-1:0]        cfg_words,
    input  logic                    beat_valid,
    input  logic                    beat_first,
    input  logic                    beat_last,
    input  logic [MIS_W-1:0]        mismatch,
    output logic                    close_valid,
    output logic                    close_bit,
    output logic signed [ACC_W-1:0] acc_sum
);
    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [TAU_W-1:0] tau;
        logic [CNT_W-1:0]        words;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic signed [ACC_W-1:0] total_bits, preset, base, sum_new;

    always_comb begin
        st_d       = st_q;
        total_bits = signed'(ACC_W'(st_q.words) * ACC_W'(NI));
        preset     = total_bits - {{(ACC_W-TAU_W){st_q.tau[TAU_W-1]}}, st_q.tau};
        base       = beat_first ? preset : st_q.acc;
        sum_new    = base - signed'(ACC_W'({mismatch, 1'b0}));
        if (beat_valid) begin
            st_d.acc = sum_new;
        end
        if (cfg_load) begin
            st_d.tau   = cfg_tau;
            st_d.words = cfg_words;
        end
        close_valid = beat_valid && beat_last;
        close_bit   = ~sum_new[ACC_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_sum = st_q.acc;
endmodule

// File: rtl/bnn_or_pool.sv
module bnn_or_pool
    import bnn_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic close_valid,
    input  logic close_bit,
    input  logic close_pool_last,
    output logic out_valid,
    output logic out_bit,
    output logic held
);
    pool_state_t ps_d, ps_q;
    logic pooled;

    always_comb begin
        ps_d        = ps_q;
        ps_d.ovalid = 1'b0;
        pooled      = ps_q.held | close_bit;
        if (close_valid) begin
            if (close_pool_last) begin
                ps_d.ovalid = 1'b1;
                ps_d.obit   = pooled;
                ps_d.held   = 1'b0;
            end else begin
                ps_d.held   = pooled;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign out_valid = ps_q.ovalid;
    assign out_bit   = ps_q.obit;
    assign held      = ps_q.held;
endmodule

// File: rtl/bnn_xnor_core.sv
module bnn_xnor_core
    import bnn_core_pkg::*;
#(
    parameter int NI        = 64,
    parameter int MAX_WORDS = 64,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_load,
    input  logic signed [TAU_W-1:0] cfg_tau,
    input  logic [CNT_W-1:0]        cfg_words,
    input  logic                    in_valid,
    input  logic                    in_first,
    input  logic                    in_last,
    input  logic                    pool_last,
    input  logic [NI-1:0]           act_word,
    input  logic [NI-1:0]           wgt_word,
    output logic                    out_valid,
    output logic                    out_bit
);
    localparam int MIS_W   = $clog2(NI + 1);
    localparam int TOTAL_W = $clog2(MAX_WORDS * NI + 1);
    localparam int ACC_W   = ((TOTAL_W > TAU_W) ? TOTAL_W : TAU_W) + 4;

    logic [MIS_W-1:0]        mismatch;
    logic                    close_valid, close_bit;
    logic signed [ACC_W-1:0] acc_sum;
    logic                    pool_held;

    bnn_mismatch_count #(.NI(NI), .MIS_W(MIS_W)) u_count (
        .act   (act_word),
        .wgt   (wgt_word),
        .count (mismatch)
    );

    bnn_thresh_acc #(.NI(NI), .ACC_W(ACC_W), .CNT_W(CNT_W), .MIS_W(MIS_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_load    (cfg_load),
        .cfg_tau     (cfg_tau),
        .cfg_words   (cfg_words),
        .beat_valid  (in_valid),
        .beat_first  (in_first),
        .beat_last   (in_last),
        .mismatch    (mismatch),
        .close_valid (close_valid),
        .close_bit   (close_bit),
        .acc_sum     (acc_sum)
    );

    bnn_or_pool u_pool (
        .clk             (clk),
        .rst_n           (rst_n),
        .close_valid     (close_valid),
        .close_bit       (close_bit),
        .close_pool_last (pool_last),
        .out_valid       (out_valid),
        .out_bit         (out_bit),
        .held            (pool_held)
    );
endmodule

// File: rtl/bnn_xnor_core_chk.sv
module bnn_xnor_core_chk #(
    parameter int ACC_W = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_first,
    input logic                    in_last,
    input logic                    pool_last,
    input logic                    out_valid,
    input logic                    out_bit,
    input logic signed [ACC_W-1:0] acc_sum,
    input logic                    pool_held
);
    // R5: accumulator wide enough for the supported sizes
    initial a_acc_width_r5: assert (ACC_W >= 20);

    p_emit_follows_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_last && pool_last));

    p_close_emits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && pool_last) |=> out_valid);

    p_pool_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last && pool_last) |=> !pool_held);

    p_sum_nonincr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_first) |=> (acc_sum <= $past(acc_sum)));

    p_idle_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(acc_sum) && $stable(pool_held)));

    p_bit_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_bit));
endmodule

bind bnn_xnor_core bnn_xnor_core_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_last   (in_last),
    .pool_last (pool_last),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .acc_sum   (acc_sum),
    .pool_held (pool_held)
);

// File: tb/bnn_xnor_core_test.sv
module bnn_xnor_core_test;
    localparam int NI    = 64;
    localparam int MAXW  = 64;
    localparam int CNT_W = $clog2(MAXW + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_load;
    logic signed [15:0] cfg_tau;
    logic [CNT_W-1:0]  cfg_words;
    logic              in_valid, in_first, in_last, pool_last;
    logic [NI-1:0]     act_word, wgt_word;
    logic              out_valid, out_bit;

    bnn_xnor_core #(.NI(NI), .MAX_WORDS(MAXW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_tau(cfg_tau),
        .cfg_words(cfg_words), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .pool_last(pool_last), .act_word(act_word),
        .wgt_word(wgt_word), .out_valid(out_valid), .out_bit(out_bit)
    );

    always #10 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int   m_tau  = 0;
    int   m_sum  = 0;
    logic m_pool = 1'b0;
    logic exp_v  = 1'b0;
    logic exp_b  = 1'b0;

    task automatic check_out();
        n_tests++;
        if (out_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s/R8 out_valid actual=%0b expected=%0b at %0t", cur_req, out_valid, exp_v, $time);
        end else if (exp_v && out_bit !== exp_b) begin
            n_fail++;
            $display("FAIL %s out_bit actual=%0b expected=%0b at %0t", cur_req, out_bit, exp_b, $time);
        end
    endtask

    task automatic tick(input logic v, input logic f, input logic l, input logic pl,
                        input logic [NI-1:0] a, input logic [NI-1:0] w);
        @(negedge clk);
        check_out();
        cfg_load = 1'b0;
        in_valid = v; in_first = f; in_last = l; pool_last = pl;
        act_word = a; wgt_word = w;
        exp_v = 1'b0;
        if (v) begin
            int s = 0;
            for (int k = 0; k < NI; k++) s += (a[k] == w[k]) ? 1 : -1;
            if (f) m_sum = 0;
            m_sum += s;
            if (l) begin
                logic bitv, pooled;
                bitv   = (m_sum >= m_tau);
                pooled = m_pool | bitv;
                if (pl) begin
                    exp_v = 1'b1; exp_b = pooled; m_pool = 1'b0;
                end else begin
                    m_pool = pooled;
                end
            end
        end
    endtask

    task automatic load_cfg(input int tau, input int words);
        @(negedge clk);
        check_out();
        cfg_load = 1'b1; cfg_tau = 16'(tau); cfg_words = CNT_W'(words);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; pool_last = 1'b0;
        exp_v = 1'b0;
        m_tau = tau;
    endtask

    function automatic logic [NI-1:0] rnd_word();
        logic [NI-1:0] r;
        for (int k = 0; k < NI; k++) r[k] = 1'($urandom_range(0, 1));
        return r;
    endfunction

    function automatic logic [NI-1:0] low_mask(input int n);
        logic [NI-1:0] r = '0;
        for (int k = 0; k < NI; k++) r[k] = (k < n);
        return r;
    endfunction

    // one dot product of random words with optional idle gaps carrying garbage
    task automatic rnd_dot(input int words, input logic pl, input bit gaps);
        for (int w = 0; w < words; w++) begin
            if (gaps && $urandom_range(0, 2) == 0)
                tick(1'b0, 1'($urandom_range(0,1)), 1'($urandom_range(0,1)), 1'b1, rnd_word(), rnd_word());
            tick(1'b1, w == 0, w == words - 1, pl, rnd_word(), rnd_word());
        end
    endtask

    task automatic idle();
        tick(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NI-1:0] a;
        rst_n = 1'b0; cfg_load = 1'b0; cfg_tau = '0; cfg_words = '0;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; pool_last = 1'b0;
        act_word = '0; wgt_word = '0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check_out();
        rst_n = 1'b1;
        idle();

        // R4/R7: full agreement and full disagreement, tau = 0
        cur_req = "R4";
        load_cfg(0, 1);
        a = rnd_word();
        tick(1'b1, 1'b1, 1'b1, 1'b1, a, a);
        tick(1'b1, 1'b1, 1'b1, 1'b1, a, ~a);
        idle(); idle();

        // R4: exact tie S == tau (S = 64 + 64 - 2*58 = 12)
        cur_req = "R4";
        load_cfg(12, 2);
        a = rnd_word();
        tick(1'b1, 1'b1, 1'b0, 1'b1, a, a);
        tick(1'b1, 1'b0, 1'b1, 1'b1, a, a ^ low_mask(58));
        idle();
        load_cfg(13, 2);
        tick(1'b1, 1'b1, 1'b0, 1'b1, a, a);
        tick(1'b1, 1'b0, 1'b1, 1'b1, a, a ^ low_mask(58));
        idle();

        // R5: extremes over the maximum word count
        cur_req = "R5";
        load_cfg(-32768, MAXW);
        for (int w = 0; w < MAXW; w++) begin
            a = rnd_word();
            tick(1'b1, w == 0, w == MAXW - 1, 1'b1, a, a);
        end
        idle();
        load_cfg(32767, MAXW);
        for (int w = 0; w < MAXW; w++) begin
            a = rnd_word();
            tick(1'b1, w == 0, w == MAXW - 1, 1'b1, a, ~a);
        end
        idle();
        load_cfg(-4096, MAXW);
        for (int w = 0; w < MAXW; w++) begin
            a = rnd_word();
            tick(1'b1, w == 0, w == MAXW - 1, 1'b1, a, ~a);
        end
        idle();

        // R10: single-word dot products with random data and thresholds
        cur_req = "R10";
        for (int i = 0; i < 20; i++) begin
            load_cfg(int'($urandom_range(0, 16)) - 8, 1);
            rnd_dot(1, 1'b1, 1'b0);
        end
        idle();

        // R7/R2/R3: pool size 1, random lengths and thresholds, back to back
        cur_req = "R7";
        for (int i = 0; i < 40; i++) begin
            int words = $urandom_range(1, 8);
            int r     = 2 * words;
            load_cfg(int'($urandom_range(0, 2 * r)) - r, words);
            rnd_dot(words, 1'b1, 1'b0);
        end
        idle();

        // R6: windows of four results ORed together
        cur_req = "R6";
        for (int g = 0; g < 12; g++) begin
            int words = $urandom_range(1, 4);
            load_cfg(int'($urandom_range(0, 24)) - (g % 3 == 0 ? 0 : 12), words);
            for (int p = 0; p < 4; p++) rnd_dot(words, p == 3, 1'b0);
            idle();
        end
        // R6: window of all-zero results after a window holding a one
        load_cfg(-64, 1);
        a = rnd_word();
        tick(1'b1, 1'b1, 1'b1, 1'b0, a, a);
        tick(1'b1, 1'b1, 1'b1, 1'b1, a, ~a);
        load_cfg(0, 1);
        for (int p = 0; p < 4; p++) tick(1'b1, 1'b1, 1'b1, p == 3, a, ~a);
        idle();

        // R9: idle gaps with garbage flags and data inside dot products
        cur_req = "R9";
        for (int i = 0; i < 25; i++) begin
            int words = $urandom_range(1, 6);
            load_cfg(int'($urandom_range(0, 12)) - 6, words);
            rnd_dot(words, 1'($urandom_range(0, 1)), 1'b1);
        end
        rnd_dot(1, 1'b1, 1'b0);
        idle(); idle();

        @(negedge clk);
        check_out();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule